// File: doc/BRIEF.md
# Flash Programming Control Unit

This block is the software-facing control and status word for a nonvolatile-memory sequencer. Software picks an operation code, sets a write-enable flag, writes two fixed keys to a key register and then sets a start bit. The block then either issues a word program, row program, page erase or whole-array erase to a behavioural flash array model and waits for its completion, or finishes at once for no-operation codes, reserved codes and targets that are write-protected.

Status comes back in the same word: a busy/start bit that hardware clears, a sticky error flag, a sticky low-voltage error flag and a live low-voltage status bit. The two sticky flags are cleared only by starting the all-zero no-operation code. Register access is a plain single-cycle write strobe with a select (0 = control word, 1 = key register) and a combinational read of the control word. There is no back-pressure: every write is taken in the cycle it is presented.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset the control word reads 32'h0000_0000 and no flash start is issued.
- R2: Control-word bits 31..16 and 10..4 always read 0, whatever was written to them.
- R3: Bit 14 (write enable) takes the written value on every control write; bits 3..0 (operation code) take the written value only if write enable was 0 before that write.
- R4: Bit 15 (start) is set by a control write with bit 15 = 1 only when write enable was already 1, no operation is running and the key unlock is open; otherwise the write's bit 15 is ignored.
- R5: The unlock opens only after a key write of 32'hAA996655 followed by a key write of 32'h556699AA with no control write between them; it closes after UNLOCK_WIN cycles without access, on any control write, or on a key write, so a wrong key order, an intervening access or a late start leaves bit 15 at 0.
- R6: Starting code 0001 (word), 0011 (row), 0100 (page erase) or 0101 (array erase) on an unprotected target gives exactly one flash_start pulse carrying that code on flash_op; bit 15 stays 1 until the array reports done, then reads 0.
- R7: Word, row and page operations whose address page (nvm_addr[ADDR_W-1:PAGE_SHIFT]) has its prot_mask bit set, and an array erase while any prot_mask bit is set, issue no flash start, set bit 13 (error), and clear bit 15 one cycle after the start.
- R8: Starting a reserved code (0111 through 1111) issues no flash start, sets bit 13 and clears bit 15 one cycle after the start.
- R9: Starting code 0000 clears bits 13 and 12 with no flash start; codes 0010 and 0110 issue nothing and leave both flags unchanged; bit 13 is sticky across later successful operations.
- R10: While write enable is 1, bit 11 follows lv_in one cycle late and is 0 while write enable is 0; lv_in high during a running flash operation sets bit 12 at once and sets bit 13 when the operation completes.
- R11: A control write with bit 15 = 0 during a running operation neither aborts it nor clears bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_sel | input | 1 | Write target: 0 control word, 1 key register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word readback |
| nvm_addr | input | ADDR_W | Target address of the operation |
| prot_mask | input | 2**(ADDR_W-PAGE_SHIFT) | Write-protect flag per page |
| lv_in | input | 1 | Low-voltage indication from the supply monitor |
| flash_start | output | 1 | One-cycle start pulse to the array |
| flash_op | output | 4 | Operation code sent with the start |
| flash_addr | output | ADDR_W | Address sent with the start |

## Verification
The hardest state to reach is a low-voltage event that lands inside a running erase, because it needs write enable, a fresh unlock, an unprotected target and a timed lv_in pulse all at once. The bench walks the operation code through the write-enable-low window, sends both keys back to back, starts a page erase and raises lv_in two cycles into the busy period, then checks the live and sticky low-voltage bits and the error bit that appears at completion. A scoreboard queue holds the operation codes the bench expects to reach the array, so protected, reserved and unlock-failed starts are caught if they leak a pulse.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
  localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;

  localparam int BIT_GO    = 15;
  localparam int BIT_ARM   = 14;
  localparam int BIT_ERR   = 13;
  localparam int BIT_LVERR = 12;
  localparam int BIT_LVNOW = 11;

  localparam logic [3:0] OPC_CLEAR = 4'b0000;
  localparam logic [3:0] OPC_WORD  = 4'b0001;
  localparam logic [3:0] OPC_IDLE2 = 4'b0010;
  localparam logic [3:0] OPC_ROW   = 4'b0011;
  localparam logic [3:0] OPC_PAGE  = 4'b0100;
  localparam logic [3:0] OPC_CHIP  = 4'b0101;
  localparam logic [3:0] OPC_IDLE6 = 4'b0110;

  typedef enum logic [1:0] {K_CLEAR, K_IDLEOP, K_RESV, K_FLASH} op_kind_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_QUICK, SQ_BUSY} seq_e;
  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;

endpackage

// File: rtl/fpc_unlock.sv
module fpc_unlock
  import fpc_pkg::*;
#(
  parameter int UNLOCK_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr_i,
  input  logic        ctl_wr_i,
  input  logic [31:0] data_i,
  output logic        unlocked_o
);

  localparam int CW = $clog2(UNLOCK_WIN + 1);

  unlock_e        st_q;
  logic [CW-1:0]  win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= UL_IDLE;
      win_q <= '0;
    end else if (key_wr_i) begin
      if (data_i == KEY_FIRST) begin
        st_q  <= UL_HALF;
        win_q <= '0;
      end else if (st_q == UL_HALF && data_i == KEY_SECOND) begin
        st_q  <= UL_OPEN;
        win_q <= CW'(UNLOCK_WIN);
      end else begin
        st_q  <= UL_IDLE;
        win_q <= '0;
      end
    end else if (ctl_wr_i) begin
      st_q  <= UL_IDLE;
      win_q <= '0;
    end else if (st_q == UL_OPEN) begin
      if (win_q <= CW'(1)) st_q <= UL_IDLE;
      win_q <= win_q - CW'(1);
    end
  end

  assign unlocked_o = (st_q == UL_OPEN);

  // R5
  unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> ($past(key_wr_i) && $past(data_i) == KEY_SECOND));

  // R5
  unlock_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(unlocked_o) && $past(ctl_wr_i)) |-> !unlocked_o);

endmodule

// File: rtl/fpc_guard.sv
module fpc_guard
  import fpc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_SHIFT = 9
) (
  input  logic [3:0]                         op_i,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]       page_i,
  input  logic [(1<<(ADDR_W-PAGE_SHIFT))-1:0] prot_i,
  output op_kind_e                           kind_o,
  output logic                               blocked_o
);

  localparam int PG_W  = ADDR_W - PAGE_SHIFT;
  localparam int PAGES = 1 << PG_W;

  logic [PAGES-1:0] hit;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign hit[p] = prot_i[p] && (page_i == PG_W'(p));
  end

  always_comb begin
    blocked_o = 1'b0;
    kind_o    = K_RESV;
    case (op_i)
      OPC_CLEAR: kind_o = K_CLEAR;
      OPC_IDLE2,
      OPC_IDLE6: kind_o = K_IDLEOP;
      OPC_WORD,
      OPC_ROW,
      OPC_PAGE: begin
        kind_o    = K_FLASH;
        blocked_o = |hit;
      end
      OPC_CHIP: begin
        kind_o    = K_FLASH;
        blocked_o = |prot_i;
      end
      default: kind_o = K_RESV;
    endcase
  end

  // R7
  always_comb begin
    guard_chip_chk: assert (!(op_i == OPC_CHIP && prot_i != '0) || blocked_o);
  end

endmodule

// File: rtl/fpc_array_model.sv
module fpc_array_model
  import fpc_pkg::*;
#(
  parameter int WORD_LAT = 4,
  parameter int ROW_LAT  = 8,
  parameter int PAGE_LAT = 12,
  parameter int CHIP_LAT = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [3:0] op_i,
  output logic       done_o
);

  localparam int CW = $clog2(CHIP_LAT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lat;
  logic          busy_q;
  logic          done_q;

  always_comb begin
    case (op_i)
      OPC_WORD: lat = CW'(WORD_LAT);
      OPC_ROW:  lat = CW'(ROW_LAT);
      OPC_PAGE: lat = CW'(PAGE_LAT);
      OPC_CHIP: lat = CW'(CHIP_LAT);
      default:  lat = CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= lat;
      end else if (busy_q) begin
        if (cnt_q <= CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign done_o = done_q;

  // R6
  start_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import fpc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_SHIFT = 9,
  parameter int UNLOCK_WIN = 4,
  parameter int WORD_LAT   = 4,
  parameter int ROW_LAT    = 8,
  parameter int PAGE_LAT   = 12,
  parameter int CHIP_LAT   = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_wr,
  input  logic                                reg_sel,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  input  logic [ADDR_W-1:0]                   nvm_addr,
  input  logic [(1<<(ADDR_W-PAGE_SHIFT))-1:0] prot_mask,
  input  logic                                lv_in,
  output logic                                flash_start,
  output logic [3:0]                          flash_op,
  output logic [ADDR_W-1:0]                   flash_addr
);

  logic ctl_wr;
  logic key_wr;
  assign ctl_wr = reg_wr && !reg_sel;
  assign key_wr = reg_wr && reg_sel;

  logic              go_q, arm_q, err_q, lverr_q, lvnow_q, lv_seen_q;
  logic              pend_err_q, pend_clr_q, fl_start_q;
  logic [3:0]        opsel_q, fl_op_q;
  logic [ADDR_W-1:0] fl_addr_q;
  seq_e              st_q;

  logic     unlocked;
  logic     blocked;
  logic     fl_done;
  op_kind_e kind;

  fpc_unlock #(.UNLOCK_WIN(UNLOCK_WIN)) u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr_i   (key_wr),
    .ctl_wr_i   (ctl_wr),
    .data_i     (reg_wdata),
    .unlocked_o (unlocked)
  );

  fpc_guard #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_guard (
    .op_i      (opsel_q),
    .page_i    (nvm_addr[ADDR_W-1:PAGE_SHIFT]),
    .prot_i    (prot_mask),
    .kind_o    (kind),
    .blocked_o (blocked)
  );

  fpc_array_model #(
    .WORD_LAT (WORD_LAT),
    .ROW_LAT  (ROW_LAT),
    .PAGE_LAT (PAGE_LAT),
    .CHIP_LAT (CHIP_LAT)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (fl_start_q),
    .op_i    (fl_op_q),
    .done_o  (fl_done)
  );

  logic accept;
  logic lv_hit;
  assign accept = ctl_wr && reg_wdata[BIT_GO] && arm_q && unlocked && !go_q;
  assign lv_hit = lv_in && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q       <= 1'b0;
      arm_q      <= 1'b0;
      err_q      <= 1'b0;
      lverr_q    <= 1'b0;
      lvnow_q    <= 1'b0;
      lv_seen_q  <= 1'b0;
      pend_err_q <= 1'b0;
      pend_clr_q <= 1'b0;
      fl_start_q <= 1'b0;
      opsel_q    <= '0;
      fl_op_q    <= '0;
      fl_addr_q  <= '0;
      st_q       <= SQ_IDLE;
    end else begin
      lvnow_q    <= lv_hit;
      fl_start_q <= 1'b0;
      if (ctl_wr) begin
        arm_q <= reg_wdata[BIT_ARM];
        if (!arm_q) opsel_q <= reg_wdata[3:0];
      end
      case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            go_q      <= 1'b1;
            fl_op_q   <= opsel_q;
            fl_addr_q <= nvm_addr;
            if (kind == K_FLASH && !blocked) begin
              st_q       <= SQ_BUSY;
              fl_start_q <= 1'b1;
              lv_seen_q  <= 1'b0;
            end else begin
              st_q       <= SQ_QUICK;
              pend_clr_q <= (kind == K_CLEAR);
              pend_err_q <= (kind == K_RESV) || (kind == K_FLASH && blocked);
            end
          end
        end
        SQ_QUICK: begin
          go_q <= 1'b0;
          st_q <= SQ_IDLE;
          if (pend_clr_q) begin
            err_q   <= 1'b0;
            lverr_q <= 1'b0;
          end
          if (pend_err_q) err_q <= 1'b1;
        end
        SQ_BUSY: begin
          if (lv_hit) begin
            lv_seen_q <= 1'b1;
            lverr_q   <= 1'b1;
          end
          if (fl_done) begin
            go_q <= 1'b0;
            st_q <= SQ_IDLE;
            if (lv_seen_q || lv_hit) err_q <= 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_GO]    = go_q;
    reg_rdata[BIT_ARM]   = arm_q;
    reg_rdata[BIT_ERR]   = err_q;
    reg_rdata[BIT_LVERR] = lverr_q;
    reg_rdata[BIT_LVNOW] = lvnow_q;
    reg_rdata[3:0]       = opsel_q;
  end

  assign flash_start = fl_start_q;
  assign flash_op    = fl_op_q;
  assign flash_addr  = fl_addr_q;

  // R4
  go_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(arm_q));

  // R3
  opsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_q) |-> $stable(opsel_q));

  // R6
  done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_done |-> (go_q && st_q == SQ_BUSY));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q == SQ_BUSY) && !$past(fl_done)) |-> go_q);

  // R10
  lvnow_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm_q) |-> !lvnow_q);

endmodule

// File: tb/flash_prog_ctl_test.sv
module flash_prog_ctl_test;
  import fpc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] nvm_addr = '0;
  logic [7:0]  prot_mask = '0;
  logic        lv_in = 1'b0;
  logic        flash_start;
  logic [3:0]  flash_op;
  logic [11:0] flash_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  flash_prog_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nvm_addr(nvm_addr),
    .prot_mask(prot_mask), .lv_in(lv_in), .flash_start(flash_start),
    .flash_op(flash_op), .flash_addr(flash_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: every flash start must match the next queued expectation.
  always @(negedge clk) begin
    if (rst_n && flash_start) begin
      if (exp_q.size() == 0) chk("R7/R8 unexpected flash start", {28'h0, flash_op}, 32'hFFFF_FFFF);
      else chk("R6 flash op", {28'h0, flash_op}, {28'h0, exp_q.pop_front()});
    end
  end

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic unlock();
    wr(1'b1, KEY_FIRST);
    wr(1'b1, KEY_SECOND);
  endtask

  task automatic set_op(input logic [3:0] op);
    wr(1'b0, 32'h0);
    wr(1'b0, 32'h4000 | op);
  endtask

  task automatic go_op(input logic [3:0] op, input bit issues);
    set_op(op);
    unlock();
    if (issues) exp_q.push_back(op);
    wr(1'b0, 32'hC000 | op);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && reg_rdata[BIT_GO]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog expired", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", reg_rdata, 32'h0);

    // R2 R3 R4: all ones, no unlock
    wr(1'b0, 32'hFFFF_FFFF);
    chk("R2 unimplemented bits zero, R4 no start", reg_rdata, 32'h0000_400F);
    wr(1'b0, 32'h0);
    chk("R3 opcode held while enabled", reg_rdata, 32'h0000_000F);
    wr(1'b0, 32'h4001);
    chk("R3 opcode written while disabled", reg_rdata, 32'h0000_4001);
    wr(1'b0, 32'h4003);
    chk("R3 opcode locked", reg_rdata, 32'h0000_4001);

    // R6 word program
    unlock();
    exp_q.push_back(OPC_WORD);
    wr(1'b0, 32'hC001);
    chk("R6 start bit set", reg_rdata, 32'h0000_C001);
    wait_idle();
    chk("R6 word program done", reg_rdata, 32'h0000_4001);

    // R4 start without unlock
    wr(1'b0, 32'hC001);
    chk("R4 start without unlock ignored", reg_rdata, 32'h0000_4001);

    // R5 interrupted, reversed, expired
    wr(1'b1, KEY_FIRST); wr(1'b0, 32'h4001); wr(1'b1, KEY_SECOND);
    wr(1'b0, 32'hC001);
    chk("R5 access between keys", reg_rdata, 32'h0000_4001);
    wr(1'b1, KEY_SECOND); wr(1'b1, KEY_FIRST);
    wr(1'b0, 32'hC001);
    chk("R5 reversed keys", reg_rdata, 32'h0000_4001);
    unlock();
    repeat (8) @(negedge clk);
    wr(1'b0, 32'hC001);
    chk("R5 unlock window expired", reg_rdata, 32'h0000_4001);

    // R4 write enable low
    wr(1'b0, 32'h0001);
    unlock();
    wr(1'b0, 32'h8001);
    chk("R4 start with enable low", reg_rdata, 32'h0000_0001);

    // R7 protected page
    prot_mask = 8'h04; nvm_addr = 12'h400;
    go_op(OPC_WORD, 1'b0);
    @(negedge clk);
    chk("R7 protected word", reg_rdata, 32'h0000_6001);
    nvm_addr = 12'h200;
    go_op(OPC_ROW, 1'b1);
    wait_idle();
    chk("R9 error sticky over row program", reg_rdata, 32'h0000_6003);
    go_op(OPC_CLEAR, 1'b0);
    @(negedge clk);
    chk("R9 clear code", reg_rdata, 32'h0000_4000);

    // R7 array erase blocked, then R11 abort attempt
    go_op(OPC_CHIP, 1'b0);
    @(negedge clk);
    chk("R7 array erase with protection", reg_rdata, 32'h0000_6005);
    prot_mask = 8'h00;
    go_op(OPC_CLEAR, 1'b0);
    @(negedge clk);
    go_op(OPC_CHIP, 1'b1);
    wr(1'b0, 32'h4000);
    chk("R11 start bit kept", reg_rdata, 32'h0000_C005);
    wait_idle();
    chk("R6 array erase done", reg_rdata, 32'h0000_4005);

    // R8 reserved, R9 idle codes
    go_op(4'h9, 1'b0);
    @(negedge clk);
    chk("R8 reserved code", reg_rdata, 32'h0000_6009);
    go_op(OPC_IDLE2, 1'b0);
    @(negedge clk);
    chk("R9 code 0010 keeps error", reg_rdata, 32'h0000_6002);
    go_op(OPC_IDLE6, 1'b0);
    @(negedge clk);
    chk("R9 code 0110 keeps error", reg_rdata, 32'h0000_6006);
    go_op(OPC_CLEAR, 1'b0);
    @(negedge clk);
    chk("R9 clear after reserved", reg_rdata, 32'h0000_4000);

    // R10 low voltage during page erase
    go_op(OPC_PAGE, 1'b1);
    @(negedge clk);
    lv_in = 1'b1;
    @(negedge clk);
    chk("R10 live and sticky low voltage", {30'h0, reg_rdata[BIT_LVERR], reg_rdata[BIT_LVNOW]}, 32'h3);
    lv_in = 1'b0;
    wait_idle();
    chk("R10 error after low voltage", reg_rdata, 32'h0000_7004);
    wr(1'b0, 32'h0004);
    lv_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 status off while disabled", reg_rdata, 32'h0000_3004);
    lv_in = 1'b0;
    go_op(OPC_CLEAR, 1'b0);
    @(negedge clk);
    chk("R9 clear low-voltage error", reg_rdata, 32'h0000_4000);

    repeat (4) @(negedge clk);
    chk("R6 all expected starts seen", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule